// File: doc/BRIEF.md
# Register-Write Command Packer

This block turns a stream of register write requests into a command buffer that a display-programming executor later downloads. Each request carries a 20-bit register offset and a 32-bit value. The block builds 64-bit instructions from pairs of 32-bit words and writes them into a buffer that sits outside the block, through a write port one doubleword (qword) wide. A write to a new register becomes a single-write instruction. When the next request targets the same register, the block turns that instruction into an indexed burst in place. Each further write to that register then only appends a value and bumps the burst's word count.

A finish request closes the buffer. The block fills it with zero words up to the next 16-word cacheline boundary and reports the resulting tail. A request that would not fit is dropped and flagged. A synchronous clear, issued once the executor has gone idle, returns the block to an empty buffer.

The block has two write ports. The main port writes both 32-bit halves of one qword, each half with its own enable. The count port rewrites only the low word of the qword that holds a burst's header. All buffer writes appear on the ports in the cycle after the request is accepted.

Top module: `cmd_packer`

## Requirements
- R1: A write whose offset differs from the previous instruction's offset, or that follows reset, clear or finish, is emitted as a single write. The word at the instruction start holds the value. The next word holds opcode 0x01 in bits [31:24], byte enable 0xF in bits [23:20] and the offset in bits [19:0]. Both words appear on the main port in the cycle after acceptance.
- R2: A single write always starts at an even word index. If the free position is odd, it is first rounded up, so the word at the odd position is skipped.
- R3: A write to the same offset as a preceding single write rewrites that instruction into a burst. The start word becomes the count 2. The next word becomes opcode 0x09 with byte-enable field 0 and the offset. The old value and the new value follow in the next two words, and the free position becomes start + 4.
- R4: Each further write to the offset of an open burst stores its value at the free position. It also rewrites the count word at the instruction start, through the count port, with the count plus one. The free position then advances by one.
- R5: When an appended value lands on an even word, the odd word after it is written as zero in the same port write.
- R6: A write request made while the free position exceeds the buffer size minus 2 words is dropped. It produces a one-cycle drop pulse, makes no buffer write and leaves the tail unchanged.
- R7: A finish request writes zero words from the free position up to the next multiple of 16 words. It sets the tail to that boundary and gives a one-cycle done pulse in the cycle the last padding write appears. If the tail is already on a boundary, the done pulse follows at once and nothing is written.
- R8: A clear sets the tail to 0 and forgets the previous instruction, so the next write is emitted as a single write at word 0 even if it repeats the last offset.
- R9: After a finish, a write to the offset of the last instruction starts a new single write and does not extend that instruction.
- R10: Ready stays high for back-to-back single writes and appends. It is low for exactly the one cycle after a request that converts a single write into a burst, and throughout finish padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of free position and instruction state |
| req_valid_i | input | 1 | Request valid |
| req_finish_i | input | 1 | 1: finish request, 0: register write request |
| req_ofs_i | input | 20 | Register offset |
| req_val_i | input | 32 | Register value |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| buf_we_o | output | 2 | Main port word enables, bit 0 even word, bit 1 odd word |
| buf_addr_o | output | $clog2(BUF_WORDS) | Main port qword index |
| buf_wdata_o | output | 64 | Main port data, even word in bits [31:0] |
| cnt_we_o | output | 1 | Count port enable |
| cnt_addr_o | output | $clog2(BUF_WORDS) | Count port qword index, writes the even word |
| cnt_wdata_o | output | 32 | Count value |
| tail_o | output | $clog2(BUF_WORDS)+1 | Free position in words |
| drop_o | output | 1 | Overflow drop pulse |
| fin_done_o | output | 1 | Finish complete pulse |

## Verification
A wrong free position shows up in the cycle after the next accepted request, as a main-port address off by one qword or as a tail value that differs from the count of words emitted. A stale or wrong instruction record gives itself away on the next same-offset write. Such a write either converts something that should have stayed a single write or opens a fresh instruction where a burst was due, and the buffer contents show it within two cycles. A wrong burst count appears on the count port at the very next append. Faults in the padding path show up as non-zero words below the tail, or as a done pulse that comes early or late against a tail off the boundary.

// File: rtl/cmdpk_pkg.sv
package cmdpk_pkg;

   localparam int unsigned OFS_BITS = 20;
   localparam int unsigned VAL_BITS = 32;

   localparam logic [7:0] OPC_SINGLE = 8'h01;
   localparam logic [7:0] OPC_BURST  = 8'h09;
   localparam logic [3:0] BE_ALL     = 4'hF;

   typedef enum logic [1:0] {
      LAST_NONE,
      LAST_SINGLE,
      LAST_BURST
   } last_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CONV,
      ST_PAD
   } pk_state_t;

   typedef enum logic [2:0] {
      WK_SINGLE,
      WK_CONV_HDR,
      WK_CONV_DATA,
      WK_APPEND,
      WK_PAD
   } wr_kind_t;

   function automatic logic [31:0] single_hdr(input logic [OFS_BITS-1:0] ofs);
      return {OPC_SINGLE, BE_ALL, ofs};
   endfunction

   function automatic logic [31:0] burst_hdr(input logic [OFS_BITS-1:0] ofs);
      return {OPC_BURST, 4'h0, ofs};
   endfunction

endpackage

// File: rtl/cmdpk_addr_calc.sv
module cmdpk_addr_calc #(
   parameter int unsigned BUF_WORDS  = 256,
   parameter int unsigned LINE_WORDS = 16,
   localparam int unsigned WAW  = $clog2(BUF_WORDS) + 1,
   localparam int unsigned QA_W = WAW - 1,
   localparam int unsigned LB   = $clog2(LINE_WORDS)
) (
   input  logic [WAW-1:0]  fp,
   output logic [QA_W-1:0] start_q,
   output logic            room_ok,
   output logic            line_edge,
   output logic [WAW-1:0]  pad_next,
   output logic            pad_last
);

   localparam logic [WAW-1:0] ROOM_LIMIT = WAW'(BUF_WORDS - 2);

   always_comb begin
      start_q   = fp[WAW-1:1] + QA_W'(fp[0]);
      room_ok   = (fp <= ROOM_LIMIT);
      line_edge = (fp[LB-1:0] == '0);
      pad_next  = fp[0] ? (fp + WAW'(1)) : (fp + WAW'(2));
      pad_last  = (pad_next[LB-1:0] == '0);
   end

endmodule

// File: rtl/cmdpk_word_fmt.sv
module cmdpk_word_fmt
   import cmdpk_pkg::*;
(
   input  wr_kind_t              kind,
   input  logic                  odd,
   input  logic [OFS_BITS-1:0]   ofs,
   input  logic [VAL_BITS-1:0]   new_val,
   input  logic [VAL_BITS-1:0]   old_val,
   input  logic [VAL_BITS-1:0]   cnt_val,
   output logic [1:0]            lane_we,
   output logic [2*VAL_BITS-1:0] lane_data
);

   logic [VAL_BITS-1:0] lane_d [2];
   logic                lane_e [2];

   for (genvar L = 0; L < 2; L++) begin : g_lane
      localparam bit IS_HI = (L == 1);
      always_comb begin
         lane_d[L] = '0;
         lane_e[L] = 1'b0;
         case (kind)
            WK_SINGLE: begin
               lane_d[L] = IS_HI ? single_hdr(ofs) : new_val;
               lane_e[L] = 1'b1;
            end
            WK_CONV_HDR: begin
               lane_d[L] = IS_HI ? burst_hdr(ofs) : cnt_val;
               lane_e[L] = 1'b1;
            end
            WK_CONV_DATA: begin
               lane_d[L] = IS_HI ? new_val : old_val;
               lane_e[L] = 1'b1;
            end
            WK_APPEND: begin
               if (IS_HI) begin
                  lane_d[L] = odd ? new_val : '0;
                  lane_e[L] = 1'b1;
               end else begin
                  lane_d[L] = new_val;
                  lane_e[L] = !odd;
               end
            end
            WK_PAD: begin
               lane_d[L] = '0;
               lane_e[L] = IS_HI || !odd;
            end
            default: begin
               lane_d[L] = '0;
               lane_e[L] = 1'b0;
            end
         endcase
      end
   end

   assign lane_we   = {lane_e[1], lane_e[0]};
   assign lane_data = {lane_d[1], lane_d[0]};

endmodule

// File: rtl/cmdpk_ctrl.sv
module cmdpk_ctrl
   import cmdpk_pkg::*;
#(
   parameter int unsigned BUF_WORDS  = 256,
   parameter int unsigned LINE_WORDS = 16,
   localparam int unsigned WAW  = $clog2(BUF_WORDS) + 1,
   localparam int unsigned QA_W = WAW - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                req_valid_i,
   input  logic                req_finish_i,
   input  logic [OFS_BITS-1:0] req_ofs_i,
   input  logic [VAL_BITS-1:0] req_val_i,
   input  logic [QA_W-1:0]     start_q,
   input  logic                room_ok,
   input  logic                line_edge,
   input  logic [WAW-1:0]      pad_next,
   input  logic                pad_last,
   output logic                rdy_o,
   output logic [WAW-1:0]      fp_o,
   output logic                wr_fire,
   output wr_kind_t            wr_kind,
   output logic [QA_W-1:0]     wr_q,
   output logic                wr_odd,
   output logic [VAL_BITS-1:0] fmt_new,
   output logic [VAL_BITS-1:0] fmt_old,
   output logic                cnt_fire,
   output logic [QA_W-1:0]     cnt_q,
   output logic [VAL_BITS-1:0] cnt_val,
   output logic                drop_now,
   output logic                done_now
);

   pk_state_t           st, st_n;
   logic [WAW-1:0]      fp, fp_n;
   logic [QA_W-1:0]     ins_q, ins_q_n;
   last_kind_t          last, last_n;
   logic [OFS_BITS-1:0] last_ofs, last_ofs_n;
   logic [VAL_BITS-1:0] last_val, last_val_n;
   logic [VAL_BITS-1:0] pend_val, pend_val_n;
   logic [WAW-1:0]      bcnt, bcnt_n;
   logic [WAW-1:0]      bcnt_inc;
   logic                accept, hit, is_single, is_append;

   assign rdy_o    = (st == ST_IDLE) && !clear_i;
   assign accept   = req_valid_i && rdy_o;
   assign hit      = (last != LAST_NONE) && (req_ofs_i == last_ofs);
   assign bcnt_inc = bcnt + WAW'(1);
   assign fp_o     = fp;
   assign fmt_old  = last_val;
   assign fmt_new  = (st == ST_CONV) ? pend_val : req_val_i;

   always_comb begin
      st_n       = st;
      fp_n       = fp;
      ins_q_n    = ins_q;
      last_n     = last;
      last_ofs_n = last_ofs;
      last_val_n = last_val;
      pend_val_n = pend_val;
      bcnt_n     = bcnt;
      wr_fire    = 1'b0;
      wr_kind    = WK_SINGLE;
      wr_q       = fp[WAW-1:1];
      wr_odd     = fp[0];
      cnt_fire   = 1'b0;
      cnt_q      = ins_q;
      cnt_val    = 32'(bcnt_inc);
      drop_now   = 1'b0;
      done_now   = 1'b0;
      is_single  = 1'b0;
      is_append  = 1'b0;
      if (clear_i) begin
         st_n    = ST_IDLE;
         fp_n    = '0;
         ins_q_n = '0;
         last_n  = LAST_NONE;
      end else begin
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  if (req_finish_i) begin
                     last_n = LAST_NONE;
                     if (line_edge) done_now = 1'b1;
                     else           st_n     = ST_PAD;
                  end else if (!room_ok) begin
                     drop_now = 1'b1;
                  end else if (hit && last == LAST_SINGLE) begin
                     wr_fire    = 1'b1;
                     wr_kind    = WK_CONV_HDR;
                     wr_q       = ins_q;
                     wr_odd     = 1'b0;
                     cnt_val    = 32'd2;
                     bcnt_n     = WAW'(2);
                     pend_val_n = req_val_i;
                     last_n     = LAST_BURST;
                     st_n       = ST_CONV;
                  end else if (hit && last == LAST_BURST) begin
                     is_append = 1'b1;
                     wr_fire   = 1'b1;
                     wr_kind   = WK_APPEND;
                     cnt_fire  = 1'b1;
                     bcnt_n    = bcnt_inc;
                     fp_n      = fp + WAW'(1);
                  end else begin
                     is_single  = 1'b1;
                     wr_fire    = 1'b1;
                     wr_kind    = WK_SINGLE;
                     wr_q       = start_q;
                     wr_odd     = 1'b0;
                     ins_q_n    = start_q;
                     fp_n       = {start_q + QA_W'(1), 1'b0};
                     last_n     = LAST_SINGLE;
                     last_ofs_n = req_ofs_i;
                     last_val_n = req_val_i;
                  end
               end
            end
            ST_CONV: begin
               wr_fire = 1'b1;
               wr_kind = WK_CONV_DATA;
               wr_q    = ins_q + QA_W'(1);
               wr_odd  = 1'b0;
               fp_n    = {ins_q + QA_W'(2), 1'b0};
               st_n    = ST_IDLE;
            end
            ST_PAD: begin
               wr_fire = 1'b1;
               wr_kind = WK_PAD;
               fp_n    = pad_next;
               if (pad_last) begin
                  st_n     = ST_IDLE;
                  done_now = 1'b1;
               end
            end
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         fp       <= '0;
         ins_q    <= '0;
         last     <= LAST_NONE;
         last_ofs <= '0;
         last_val <= '0;
         pend_val <= '0;
         bcnt     <= '0;
      end else begin
         st       <= st_n;
         fp       <= fp_n;
         ins_q    <= ins_q_n;
         last     <= last_n;
         last_ofs <= last_ofs_n;
         last_val <= last_val_n;
         pend_val <= pend_val_n;
         bcnt     <= bcnt_n;
      end
   end

   // R2: an odd free position is skipped before a single write
   assert_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_single && fp[0]) |=> (fp == $past(fp) + WAW'(3)));

   // R4: each append raises the burst count by one
   assert_burst_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_append |=> (bcnt == $past(bcnt) + WAW'(1)));

   // R10: conversion holds off the next request for one cycle
   assert_conv_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CONV) |-> !rdy_o);

   // R6: the free position never passes the buffer end
   assert_tail_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fp <= WAW'(BUF_WORDS));

endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
   import cmdpk_pkg::*;
#(
   parameter int unsigned BUF_WORDS  = 256,
   parameter int unsigned LINE_WORDS = 16,
   localparam int unsigned WAW  = $clog2(BUF_WORDS) + 1,
   localparam int unsigned QA_W = WAW - 1,
   localparam int unsigned LB   = $clog2(LINE_WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                req_valid_i,
   input  logic                req_finish_i,
   input  logic [19:0]         req_ofs_i,
   input  logic [31:0]         req_val_i,
   output logic                req_ready_o,
   output logic [1:0]          buf_we_o,
   output logic [QA_W-1:0]     buf_addr_o,
   output logic [63:0]         buf_wdata_o,
   output logic                cnt_we_o,
   output logic [QA_W-1:0]     cnt_addr_o,
   output logic [31:0]         cnt_wdata_o,
   output logic [WAW-1:0]      tail_o,
   output logic                drop_o,
   output logic                fin_done_o
);

   if (LINE_WORDS < 2 || (1 << LB) != LINE_WORDS) begin : g_bad_line
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (BUF_WORDS < LINE_WORDS || (BUF_WORDS % LINE_WORDS) != 0) begin : g_bad_buf
      $error("BUF_WORDS must be a non-zero multiple of LINE_WORDS");
   end

   logic [QA_W-1:0]  start_q;
   logic             room_ok, line_edge, pad_last;
   logic [WAW-1:0]   pad_next, fp;
   logic             wr_fire, wr_odd, cnt_fire, drop_now, done_now;
   wr_kind_t         wr_kind;
   logic [QA_W-1:0]  wr_q, cnt_q;
   logic [31:0]      fmt_new, fmt_old, cnt_val;
   logic [1:0]       lane_we;
   logic [63:0]      lane_data;

   cmdpk_addr_calc #(.BUF_WORDS(BUF_WORDS), .LINE_WORDS(LINE_WORDS)) u_addr (
      .fp        (fp),
      .start_q   (start_q),
      .room_ok   (room_ok),
      .line_edge (line_edge),
      .pad_next  (pad_next),
      .pad_last  (pad_last)
   );

   cmdpk_ctrl #(.BUF_WORDS(BUF_WORDS), .LINE_WORDS(LINE_WORDS)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (clear_i),
      .req_valid_i  (req_valid_i),
      .req_finish_i (req_finish_i),
      .req_ofs_i    (req_ofs_i),
      .req_val_i    (req_val_i),
      .start_q      (start_q),
      .room_ok      (room_ok),
      .line_edge    (line_edge),
      .pad_next     (pad_next),
      .pad_last     (pad_last),
      .rdy_o        (req_ready_o),
      .fp_o         (fp),
      .wr_fire      (wr_fire),
      .wr_kind      (wr_kind),
      .wr_q         (wr_q),
      .wr_odd       (wr_odd),
      .fmt_new      (fmt_new),
      .fmt_old      (fmt_old),
      .cnt_fire     (cnt_fire),
      .cnt_q        (cnt_q),
      .cnt_val      (cnt_val),
      .drop_now     (drop_now),
      .done_now     (done_now)
   );

   cmdpk_word_fmt u_fmt (
      .kind      (wr_kind),
      .odd       (wr_odd),
      .ofs       (req_ofs_i),
      .new_val   (fmt_new),
      .old_val   (fmt_old),
      .cnt_val   (cnt_val),
      .lane_we   (lane_we),
      .lane_data (lane_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_we_o    <= '0;
         buf_addr_o  <= '0;
         buf_wdata_o <= '0;
         cnt_we_o    <= 1'b0;
         cnt_addr_o  <= '0;
         cnt_wdata_o <= '0;
         drop_o      <= 1'b0;
         fin_done_o  <= 1'b0;
      end else begin
         buf_we_o    <= wr_fire ? lane_we : 2'b00;
         buf_addr_o  <= wr_q;
         buf_wdata_o <= lane_data;
         cnt_we_o    <= cnt_fire;
         cnt_addr_o  <= cnt_q;
         cnt_wdata_o <= cnt_val;
         drop_o      <= drop_now;
         fin_done_o  <= done_now;
      end
   end

   assign tail_o = fp;

   // R6: a dropped request writes nothing
   assert_drop_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |-> (buf_we_o == 2'b00 && !cnt_we_o));

   // R7: finish completes on a cacheline boundary
   assert_done_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fin_done_o |-> (tail_o[LB-1:0] == '0));

   // R8: clear empties the buffer position
   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (tail_o == '0));

endmodule

// File: tb/cmd_packer_bench.sv
module cmd_packer_bench;

   localparam int unsigned BW  = 64;
   localparam int unsigned WAW = $clog2(BW) + 1;
   localparam int unsigned QAW = WAW - 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           clr = 1'b0;
   logic           vld = 1'b0;
   logic           fin = 1'b0;
   logic [19:0]    ofs = '0;
   logic [31:0]    val = '0;
   logic           rdy;
   logic [1:0]     bwe;
   logic [QAW-1:0] baddr;
   logic [63:0]    bdata;
   logic           cwe;
   logic [QAW-1:0] caddr;
   logic [31:0]    cdata;
   logic [WAW-1:0] tail;
   logic           drop, done;

   int checks = 0;
   int errors = 0;
   logic [31:0] mem [0:(2**WAW)-1];

   always #4 clk = ~clk;

   cmd_packer #(.BUF_WORDS(BW), .LINE_WORDS(16)) u_cmd_packer (
      .clk(clk), .rst_n(rst_n), .clear_i(clr),
      .req_valid_i(vld), .req_finish_i(fin), .req_ofs_i(ofs), .req_val_i(val),
      .req_ready_o(rdy), .buf_we_o(bwe), .buf_addr_o(baddr), .buf_wdata_o(bdata),
      .cnt_we_o(cwe), .cnt_addr_o(caddr), .cnt_wdata_o(cdata),
      .tail_o(tail), .drop_o(drop), .fin_done_o(done)
   );

   always @(posedge clk) begin
      if (bwe[0]) mem[int'({baddr, 1'b0})] <= bdata[31:0];
      if (bwe[1]) mem[int'({baddr, 1'b1})] <= bdata[63:32];
      if (cwe)    mem[int'({caddr, 1'b0})] <= cdata;
   end

   function automatic logic [31:0] hs(input logic [19:0] o);
      return {8'h01, 4'hF, o};
   endfunction
   function automatic logic [31:0] hb(input logic [19:0] o);
      return {8'h09, 4'h0, o};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic f, input logic [19:0] o, input logic [31:0] v);
      while (!rdy) @(negedge clk);
      vld = 1'b1; fin = f; ofs = o; val = v;
      @(negedge clk);
      vld = 1'b0; fin = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_done(output logic seen);
      seen = done;
      for (int i = 0; i < 20 && !seen; i++) begin
         @(negedge clk);
         seen = done;
      end
   endtask

   task automatic t_reset();
      chk("R8 reset tail", 32'(tail), 0);
      chk("R10 reset ready", 32'(rdy), 1);
      chk("R1 reset no write", 32'(bwe), 0);
   endtask

   task automatic t_singles();
      send(1'b0, 20'h00100, 32'hA0A0A0A0);
      chk("R10 ready after single", 32'(rdy), 1);
      send(1'b0, 20'h00104, 32'hB1B1B1B1);
      settle();
      chk("R1 value word", mem[0], 32'hA0A0A0A0);
      chk("R1 header word", mem[1], hs(20'h00100));
      chk("R1 second header", mem[3], hs(20'h00104));
      chk("R1 tail", 32'(tail), 4);
   endtask

   task automatic t_merge();
      logic r;
      send(1'b0, 20'h00104, 32'hC2C2C2C2);
      r = rdy;
      chk("R10 ready low in conversion", 32'(r), 0);
      settle();
      chk("R3 count", mem[2], 2);
      chk("R3 burst header", mem[3], hb(20'h00104));
      chk("R3 old value", mem[4], 32'hB1B1B1B1);
      chk("R3 new value", mem[5], 32'hC2C2C2C2);
      chk("R3 tail", 32'(tail), 6);
   endtask

   task automatic t_append();
      send(1'b0, 20'h00104, 32'hD3D3D3D3);
      settle();
      chk("R4 append value", mem[6], 32'hD3D3D3D3);
      chk("R5 pad after even append", mem[7], 0);
      chk("R4 count 3", mem[2], 3);
      chk("R4 tail 7", 32'(tail), 7);
      send(1'b0, 20'h00104, 32'hE4E4E4E4);
      send(1'b0, 20'h00104, 32'hF5F5F5F5);
      settle();
      chk("R4 odd append", mem[7], 32'hE4E4E4E4);
      chk("R4 count 5", mem[2], 5);
      chk("R5 pad word 9", mem[9], 0);
      chk("R4 tail 9", 32'(tail), 9);
   endtask

   task automatic t_align();
      send(1'b0, 20'h00200, 32'h66666666);
      settle();
      chk("R2 skipped odd word", mem[9], 0);
      chk("R2 value at even start", mem[10], 32'h66666666);
      chk("R2 header", mem[11], hs(20'h00200));
      chk("R2 tail", 32'(tail), 12);
   endtask

   task automatic t_finish();
      logic seen;
      send(1'b1, 20'h0, 32'h0);
      wait_done(seen);
      chk("R7 done pulse", 32'(seen), 1);
      chk("R7 tail boundary", 32'(tail), 16);
      settle();
      for (int i = 12; i < 16; i++) chk("R7 pad zero", mem[i], 0);
      send(1'b0, 20'h00200, 32'h77777777);
      settle();
      chk("R9 new single value", mem[16], 32'h77777777);
      chk("R9 new single header", mem[17], hs(20'h00200));
      chk("R9 tail", 32'(tail), 18);
   endtask

   task automatic t_clear_fill();
      logic seen;
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      chk("R8 clear tail", 32'(tail), 0);
      for (int i = 0; i < 32; i++) send(1'b0, 20'h00300 + 20'(i), 32'h1000 + 32'(i));
      settle();
      chk("R6 last fitting value", mem[62], 32'h101F);
      chk("R6 last fitting header", mem[63], hs(20'h0031F));
      chk("R6 full tail", 32'(tail), 64);
      send(1'b0, 20'h00400, 32'h99999999);
      chk("R6 drop pulse", 32'(drop), 1);
      chk("R6 no write on drop", 32'(bwe), 0);
      settle();
      chk("R6 tail unchanged", 32'(tail), 64);
      chk("R6 buffer untouched", mem[63], hs(20'h0031F));
      send(1'b1, 20'h0, 32'h0);
      seen = done;
      chk("R7 aligned finish at once", 32'(seen), 1);
      chk("R7 aligned tail", 32'(tail), 64);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      chk("R8 second clear tail", 32'(tail), 0);
      send(1'b0, 20'h0031F, 32'h55555555);
      settle();
      chk("R8 single after clear", mem[1], hs(20'h0031F));
      chk("R8 value after clear", mem[0], 32'h55555555);
      chk("R8 tail after clear", 32'(tail), 2);
   endtask

   initial begin
      for (int i = 0; i < 2**WAW; i++) mem[i] = 32'hDEADBEEF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_singles();
      t_merge();
      t_append();
      t_align();
      t_finish();
      t_clear_fill();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule